// File: doc/BRIEF.md
# Addressed Serial Command Front End for a Display Controller

This block is the serial slave port of a display controller. A host opens a transfer by pulling chip select low and then clocks in bytes, most significant bit first. The first byte of each transfer is a header. It holds a five-bit fixed prefix, one identity bit that must match the `id_sel` pin, a register-select bit and a direction bit. When the header matches, the data bytes that follow are paired into 16-bit words. Each completed word becomes a one-cycle strobe toward the index register, the instruction registers or the graphics RAM. A RAM word is also presented widened to an 18-bit pixel.

In a read transfer the block asks the surrounding logic for 16-bit words through a request pulse, and shifts them out on the serial output. The first four bytes after the header are dummies. Requests are issued early so that each word is buffered before its first bit is needed. All serial inputs are brought into the system clock domain through synchronisers. The system clock must run at least four times faster than the serial clock. Read transfers need a serial half period longer than four system clocks, because the serial output follows the falling serial edge with synchroniser latency.

Top module: `disp_spi_slave`

## Requirements
- R1: The header byte is the first byte after chip select falls. Its bits [7:3] must equal 01110 and bit [2] must equal `id_sel` for the device to be selected. Bit [1] is the register select (RS) and bit [0] is the direction (RW, 1 = read).
- R2: After a non-matching header, no write strobe and no `rd_req` occur and `spi_sdo` stays 0 until chip select rises.
- R3: With RS=0 and RW=0, every pair of data bytes produces one `idx_wr_stb` pulse, with `wr_word` = {first byte, second byte}.
- R4: With RS=1 and RW=0, every pair produces `cmd_wr_stb` when `ram_target`=0, or `ram_wr_stb` when `ram_target`=1, with `wr_word` = {first byte, second byte}.
- R5: While `ram_wr_stb` is high, `wr_pixel` = {w[15:11], w[15], w[10:5], w[4:0], w[4]}, where w is `wr_word`.
- R6: Consecutive byte pairs within one transfer each produce their own strobe, in arrival order.
- R7: A partial byte or an unpaired byte pending when chip select rises produces no strobe. The next transfer starts again with a header byte.
- R8: Each write strobe lasts exactly one system clock, and at most one of the three write strobes is high in any cycle.
- R9: In a read transfer the four bytes after the header are shifted out as 0x00. The bytes that follow are words from `rd_word`, high byte then low byte. Word n is the value of `rd_word` in the cycle after the n-th `rd_req`. `rd_status` is 1 during `rd_req` for RS=0 and 0 for RS=1.
- R10: `rd_req` pulses after the 3rd data byte and after each odd data byte from the 5th on (5, 7, 9, ...). It never pulses in write transfers.
- R11: `spi_sdo` is 0 while chip select is high and throughout write transfers.
- R12: `spi_sdo` changes only after a falling serial clock edge, and is stable while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| id_sel | input | 1 | Identity bit the header must carry |
| ram_target | input | 1 | High when data writes are meant for graphics RAM |
| idx_wr_stb | output | 1 | Index register write pulse |
| cmd_wr_stb | output | 1 | Instruction write pulse |
| ram_wr_stb | output | 1 | Graphics RAM write pulse |
| wr_word | output | 16 | Assembled write word |
| wr_pixel | output | 18 | Widened pixel for RAM writes |
| rd_req | output | 1 | Request for the next read word |
| rd_status | output | 1 | Read kind: 1 status, 0 instruction or RAM data |
| rd_word | input | 16 | Read word supplied after a request |

## Verification
The assertions assume that chip select and the serial clock are stable long enough to be seen by the synchronisers. They assume a serial half period of at least two system clocks, and more than four for reads. They also assume that serial data is steady around each rising serial edge, and that `rd_word` is valid from the cycle after `rd_req`. The stimulus meets these assumptions. It drives every input on the falling system clock edge and uses a serial half period of eight system clocks. It changes `id_sel` and `ram_target` only while chip select is high, and supplies each read word in the same cycle it sees the request.

// File: rtl/dspi_pkg.sv
// Shared constants for the serial command front end.
package dspi_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int PIX_W     = WORD_W + 2;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
endpackage

// File: rtl/dspi_sync.sv
// Multi-stage synchroniser for a group of asynchronous single-bit inputs.
// Provides the synchronised value and the value one clock older, so that
// the caller can detect edges. Assumes each input is a level that is held
// for at least two clocks.
module dspi_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync,
    output logic [W-1:0] d_prev
);
    logic [STAGES:0][W-1:0] stg;

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {(STAGES+1){RST_VAL}};
        end else begin
            stg <= {stg[STAGES-1:0], d_async};
        end
    end

    assign d_sync = stg[STAGES-1];
    assign d_prev = stg[STAGES];
endmodule

// File: rtl/dspi_rx.sv
// Receive engine. Counts bits and assembles bytes on synchronised rising
// serial edges, decodes the header byte and then hands each data byte of a
// selected transfer on as a one-cycle strobe. All state clears while chip
// select is inactive.
module dspi_rx
    import dspi_pkg::*;
#(
    parameter logic [4:0] ID_PREFIX = 5'b01110
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_act,
    input  logic                 sck_rise,
    input  logic                 sdi_bit,
    input  logic                 id_sel,
    output logic [BIT_CNT_W-1:0] bit_cnt,
    output logic                 hdr_done,
    output logic                 sel,
    output logic                 rs,
    output logic                 rw,
    output logic                 byte_stb,
    output logic [BYTE_W-1:0]    byte_val
);
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] nxt;
    logic              last_bit;
    logic              id_ok;

    assign nxt      = {shreg[BYTE_W-2:0], sdi_bit};
    assign last_bit = (bit_cnt == BIT_CNT_W'(BYTE_W-1));
    assign id_ok    = (nxt[BYTE_W-1 -: 5] == ID_PREFIX) && (nxt[2] == id_sel);

    // Shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (sck_rise) begin
            shreg   <= nxt;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Latch the header decode when the first byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            hdr_done <= 1'b0;
            sel      <= 1'b0;
            rs       <= 1'b0;
            rw       <= 1'b0;
        end else if (sck_rise && last_bit && !hdr_done) begin
            hdr_done <= 1'b1;
            sel      <= id_ok;
            rs       <= nxt[1];
            rw       <= nxt[0];
        end
    end

    // Emit completed data bytes of a selected transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_stb <= 1'b0;
            byte_val <= '0;
        end else begin
            byte_stb <= cs_act && sck_rise && last_bit && hdr_done && sel;
            if (cs_act && sck_rise && last_bit && hdr_done && sel) begin
                byte_val <= nxt;
            end
        end
    end

    AST_SEL_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> hdr_done); // R1
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bit_cnt == '0) && !hdr_done); // R7
    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && !sel) |-> !byte_stb); // R2
endmodule

// File: rtl/dspi_wr.sv
// Write path. Pairs data bytes of a write transfer into words, routes each
// word to one of three strobes by register select and RAM target, and
// widens the word into a pixel by copying each outer field's MSB below
// its LSB. Assumes RED_W + GRN_W + BLU_W equals the word width.
module dspi_wr
    import dspi_pkg::*;
#(
    parameter int RED_W = 5,
    parameter int GRN_W = 6,
    parameter int BLU_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              rs,
    input  logic              rw,
    input  logic              ram_target,
    output logic              idx_wr_stb,
    output logic              cmd_wr_stb,
    output logic              ram_wr_stb,
    output logic [WORD_W-1:0] wr_word,
    output logic [PIX_W-1:0]  wr_pixel
);
    logic              half;
    logic [BYTE_W-1:0] hi_byte;
    logic              pair_done;
    logic [RED_W-1:0]  red;
    logic [GRN_W-1:0]  grn;
    logic [BLU_W-1:0]  blu;

    assign pair_done = byte_stb && !rw && half;

    // Hold the first byte of a pair; drop it when chip select rises.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            half    <= 1'b0;
            hi_byte <= '0;
        end else if (byte_stb && !rw) begin
            half <= !half;
            if (!half) begin
                hi_byte <= byte_val;
            end
        end
    end

    // Publish the finished word and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_wr_stb <= 1'b0;
            cmd_wr_stb <= 1'b0;
            ram_wr_stb <= 1'b0;
            wr_word    <= '0;
        end else begin
            idx_wr_stb <= pair_done && !rs;
            cmd_wr_stb <= pair_done && rs && !ram_target;
            ram_wr_stb <= pair_done && rs && ram_target;
            if (pair_done) begin
                wr_word <= {hi_byte, byte_val};
            end
        end
    end

    // Widen the word into a pixel.
    always_comb begin
        red      = wr_word[WORD_W-1 -: RED_W];
        grn      = wr_word[BLU_W +: GRN_W];
        blu      = wr_word[0 +: BLU_W];
        wr_pixel = {red, red[RED_W-1], grn, blu, blu[BLU_W-1]};
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idx_wr_stb, cmd_wr_stb, ram_wr_stb})); // R8
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr_stb || cmd_wr_stb || ram_wr_stb) |=> !(idx_wr_stb || cmd_wr_stb || ram_wr_stb)); // R8
    AST_STROBE_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr_stb || cmd_wr_stb || ram_wr_stb) |-> $past(byte_stb) && !$past(rw)); // R6
endmodule

// File: rtl/dspi_rd.sv
// Read path. Counts dummy bytes, requests words from the surrounding logic
// early, buffers each word in a holding register, and moves it into the
// active register at a word boundary. The serial output is updated on
// synchronised falling serial edges and idles low otherwise. Assumes the
// requested word is valid in the cycle after the request.
module dspi_rd
    import dspi_pkg::*;
#(
    parameter int DUMMY_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_act,
    input  logic                 sck_fall,
    input  logic [BIT_CNT_W-1:0] bit_cnt,
    input  logic                 hdr_done,
    input  logic                 sel,
    input  logic                 rs,
    input  logic                 rw,
    input  logic                 byte_stb,
    input  logic [WORD_W-1:0]    rd_word,
    output logic                 rd_req,
    output logic                 rd_status,
    output logic                 sdo
);
    localparam int DCNT_W = $clog2(DUMMY_BYTES + 1);
    localparam logic [DCNT_W-1:0] DCNT_END  = DCNT_W'(DUMMY_BYTES);
    localparam logic [DCNT_W-1:0] DCNT_REQ  = DCNT_W'(DUMMY_BYTES - 2);
    localparam logic [DCNT_W-1:0] DCNT_LOAD = DCNT_W'(DUMMY_BYTES - 1);

    logic [DCNT_W-1:0]    dcnt;
    logic                 half;
    logic                 pend;
    logic [WORD_W-1:0]    hold;
    logic [WORD_W-1:0]    active;
    logic                 req_now;
    logic                 load_now;
    logic                 rd_mode;
    logic [BYTE_W-1:0]    tx_byte;
    logic [BIT_CNT_W-1:0] bit_idx;
    logic                 data_bit;

    assign rd_mode  = hdr_done && sel && rw;
    assign req_now  = byte_stb && rw &&
                      ((dcnt == DCNT_REQ) || ((dcnt == DCNT_END) && !half));
    assign load_now = byte_stb && rw &&
                      ((dcnt == DCNT_LOAD) || ((dcnt == DCNT_END) && half));
    assign tx_byte  = half ? active[BYTE_W-1:0] : active[WORD_W-1:BYTE_W];
    assign bit_idx  = BIT_CNT_W'(BYTE_W-1) - bit_cnt;
    assign data_bit = (dcnt == DCNT_END) ? tx_byte[bit_idx] : 1'b0;

    // Count dummy bytes, then track which half of a word is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            dcnt <= '0;
            half <= 1'b0;
        end else if (byte_stb && rw) begin
            if (dcnt != DCNT_END) begin
                dcnt <= dcnt + 1'b1;
            end else begin
                half <= !half;
            end
        end
    end

    // Issue requests and note that a word arrives next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req    <= 1'b0;
            rd_status <= 1'b0;
            pend      <= 1'b0;
        end else begin
            rd_req <= req_now;
            pend   <= rd_req;
            if (req_now) begin
                rd_status <= !rs;
            end
        end
    end

    // Capture the supplied word into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (pend) begin
            hold <= rd_word;
        end
    end

    // Move the held word into the shifting register at a word boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (load_now) begin
            active <= hold;
        end
    end

    // Drive the serial output on falling serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            sdo <= 1'b0;
        end else if (sck_fall) begin
            sdo <= rd_mode ? data_bit : 1'b0;
        end
    end

    AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo); // R11
    AST_SDO_WRITE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && !rw) |-> !sdo); // R11
    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> ($past(sck_fall) || !$past(cs_act))); // R12
    AST_REQ_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> $past(rw) && $past(sel)); // R10
endmodule

// File: rtl/disp_spi_slave.sv
// Top of the serial command front end. Synchronises the serial pins,
// derives edge events gated by chip select, and connects the receive,
// write and read paths. Assumes the system clock is at least four times
// the serial clock, and longer serial half periods for reads.
module disp_spi_slave
    import dspi_pkg::*;
#(
    parameter logic [4:0] ID_PREFIX   = 5'b01110,
    parameter int         SYNC_STAGES = 2,
    parameter int         DUMMY_BYTES = 4,
    parameter int         RED_W       = 5,
    parameter int         GRN_W       = 6,
    parameter int         BLU_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    input  logic              id_sel,
    input  logic              ram_target,
    output logic              idx_wr_stb,
    output logic              cmd_wr_stb,
    output logic              ram_wr_stb,
    output logic [WORD_W-1:0] wr_word,
    output logic [PIX_W-1:0]  wr_pixel,
    output logic              rd_req,
    output logic              rd_status,
    input  logic [WORD_W-1:0] rd_word
);
    logic [2:0]           pins_s;
    logic [2:0]           pins_p;
    logic                 cs_act;
    logic                 sck_rise;
    logic                 sck_fall;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic                 hdr_done;
    logic                 sel;
    logic                 rs;
    logic                 rw;
    logic                 byte_stb;
    logic [BYTE_W-1:0]    byte_val;

    dspi_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({spi_cs_n, spi_sck, spi_sdi}),
        .d_sync  (pins_s),
        .d_prev  (pins_p)
    );

    assign cs_act   = !pins_s[2];
    assign sck_rise = cs_act && pins_s[1] && !pins_p[1];
    assign sck_fall = cs_act && !pins_s[1] && pins_p[1];

    dspi_rx #(
        .ID_PREFIX (ID_PREFIX)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .sdi_bit  (pins_s[0]),
        .id_sel   (id_sel),
        .bit_cnt  (bit_cnt),
        .hdr_done (hdr_done),
        .sel      (sel),
        .rs       (rs),
        .rw       (rw),
        .byte_stb (byte_stb),
        .byte_val (byte_val)
    );

    dspi_wr #(
        .RED_W (RED_W),
        .GRN_W (GRN_W),
        .BLU_W (BLU_W)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .byte_stb   (byte_stb),
        .byte_val   (byte_val),
        .rs         (rs),
        .rw         (rw),
        .ram_target (ram_target),
        .idx_wr_stb (idx_wr_stb),
        .cmd_wr_stb (cmd_wr_stb),
        .ram_wr_stb (ram_wr_stb),
        .wr_word    (wr_word),
        .wr_pixel   (wr_pixel)
    );

    dspi_rd #(
        .DUMMY_BYTES (DUMMY_BYTES)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sck_fall  (sck_fall),
        .bit_cnt   (bit_cnt),
        .hdr_done  (hdr_done),
        .sel       (sel),
        .rs        (rs),
        .rw        (rw),
        .byte_stb  (byte_stb),
        .rd_word   (rd_word),
        .rd_req    (rd_req),
        .rd_status (rd_status),
        .sdo       (spi_sdo)
    );
endmodule

// File: tb/disp_spi_slave_bench.sv
module disp_spi_slave_bench;
    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_sdi = 1'b0;
    logic        spi_sdo;
    logic        id_sel = 1'b0;
    logic        ram_target = 1'b0;
    logic        idx_wr_stb, cmd_wr_stb, ram_wr_stb;
    logic [15:0] wr_word;
    logic [17:0] wr_pixel;
    logic        rd_req, rd_status;
    logic [15:0] rd_word = 16'h0;

    int checks = 0;
    int errors = 0;
    logic [7:0]  txb [16];
    logic [7:0]  rxb [16];
    int          mon_kind [16];
    logic [15:0] mon_word [16];
    logic [17:0] mon_pix [16];
    int mon_n = 0, req_n = 0, rd_idx = 0, unstable = 0, pulse_bad = 0;
    logic last_status = 1'b0;
    logic prev_any = 1'b0;

    always #5 clk = ~clk;

    disp_spi_slave u_disp_spi_slave (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .id_sel(id_sel),
        .ram_target(ram_target), .idx_wr_stb(idx_wr_stb),
        .cmd_wr_stb(cmd_wr_stb), .ram_wr_stb(ram_wr_stb), .wr_word(wr_word),
        .wr_pixel(wr_pixel), .rd_req(rd_req), .rd_status(rd_status),
        .rd_word(rd_word)
    );

    function automatic logic [15:0] rd_val(input int n);
        return 16'((n + 1) * 947) ^ 16'hA5C3;
    endfunction

    function automatic logic [17:0] exp_pix(input logic [15:0] w);
        return {w[15:11], w[15], w[10:5], w[4:0], w[4]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: records strobes, answers read requests.
    initial begin
        forever begin
            @(negedge clk);
            if (idx_wr_stb || cmd_wr_stb || ram_wr_stb) begin
                if (mon_n < 16) begin
                    mon_kind[mon_n] = idx_wr_stb ? 1 : (cmd_wr_stb ? 2 : 3);
                    if (int'(idx_wr_stb) + int'(cmd_wr_stb) + int'(ram_wr_stb) > 1) mon_kind[mon_n] = 9;
                    mon_word[mon_n] = wr_word;
                    mon_pix[mon_n]  = wr_pixel;
                end
                mon_n++;
                if (prev_any) pulse_bad++;
            end
            prev_any = idx_wr_stb || cmd_wr_stb || ram_wr_stb;
            if (rd_req) begin
                req_n++;
                last_status = rd_status;
                rd_word = rd_val(rd_idx);
                rd_idx++;
            end
        end
    end

    task automatic send_bit(input logic d, output logic q);
        spi_sdi = d;
        repeat (HP) @(negedge clk);
        q = spi_sdo;
        spi_sck = 1'b1;
        repeat (HP) @(negedge clk);
        if (spi_sdo !== q) unstable++;
        spi_sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] sb, input int nb, input int tail, input logic tgt);
        logic b;
        @(negedge clk);
        mon_n = 0; req_n = 0; rd_idx = 0; unstable = 0; pulse_bad = 0;
        ram_target = tgt;
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 7; i >= 0; i--) send_bit(sb[i], b);
        for (int k = 0; k < nb; k++) begin
            for (int i = 7; i >= 0; i--) begin
                send_bit(txb[k][i], b);
                rxb[k][i] = b;
            end
        end
        for (int i = 0; i < tail; i++) send_bit(1'($urandom), b);
        repeat (HP) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic check_xfer(input logic [7:0] sb, input int nb, input logic tgt);
        logic match, rs, rw;
        int exp_w, exp_r, ek;
        logic [7:0] eb;
        match = (sb[7:3] == 5'b01110) && (sb[2] == id_sel);
        rs = sb[1];
        rw = sb[0];
        exp_w = (match && !rw) ? nb / 2 : 0;
        chk(mon_n == exp_w, match ? "R6 strobe count" : "R2 strobe count", mon_n, exp_w);
        for (int w = 0; w < exp_w && w < mon_n; w++) begin
            ek = !rs ? 1 : (tgt ? 3 : 2);
            chk(mon_kind[w] == ek, rs ? "R4 strobe kind" : "R3 strobe kind", mon_kind[w], ek);
            chk(mon_word[w] == {txb[2*w], txb[2*w+1]}, rs ? "R4 word" : "R3 word",
                mon_word[w], {txb[2*w], txb[2*w+1]});
            if (ek == 3) chk(mon_pix[w] == exp_pix(mon_word[w]), "R5 pixel", mon_pix[w], exp_pix(mon_word[w]));
        end
        exp_r = 0;
        if (match && rw) for (int k = 1; k <= nb; k++) if (k == 3 || (k >= 5 && k % 2 == 1)) exp_r++;
        chk(req_n == exp_r, "R10 request count", req_n, exp_r);
        if (exp_r > 0) chk(last_status == !rs, "R9 status flag", last_status, !rs);
        for (int k = 0; k < nb; k++) begin
            if (!(match && rw) || k < 4) eb = 8'h00;
            else if ((k - 4) % 2 == 0) eb = rd_val((k - 4) / 2)[15:8];
            else eb = rd_val((k - 4) / 2)[7:0];
            chk(rxb[k] == eb, !match ? "R2 sdo byte" : (rw ? "R9 sdo byte" : "R11 sdo byte"), rxb[k], eb);
        end
        chk(unstable == 0, "R12 sdo stable in high phase", unstable, 0);
        chk(pulse_bad == 0, "R8 strobe width", pulse_bad, 0);
        chk(spi_sdo == 1'b0, "R11 sdo idle", spi_sdo, 0);
    endtask

    task automatic run(input logic [7:0] sb, input int nb, input int tail, input logic tgt);
        xfer(sb, nb, tail, tgt);
        check_xfer(sb, nb, tgt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({idx_wr_stb, cmd_wr_stb, ram_wr_stb, rd_req, spi_sdo} == 5'b0, "R8 R11 reset state",
            {idx_wr_stb, cmd_wr_stb, ram_wr_stb, rd_req, spi_sdo}, 0);

        // R3: index write, one pair.
        txb[0] = 8'h12; txb[1] = 8'h34;
        run({5'b01110, 1'b0, 2'b00}, 2, 0, 1'b0);
        // R4 R6: instruction writes, three pairs.
        for (int i = 0; i < 6; i++) txb[i] = 8'(8'h51 + i * 37);
        run({5'b01110, 1'b0, 2'b10}, 6, 0, 1'b0);
        // R4 R5: RAM writes with all-ones and alternating fields.
        txb[0] = 8'hFF; txb[1] = 8'hFF; txb[2] = 8'h84; txb[3] = 8'h10;
        run({5'b01110, 1'b0, 2'b10}, 4, 0, 1'b1);
        // R1: identity bit follows id_sel.
        id_sel = 1'b1;
        txb[0] = 8'hA5; txb[1] = 8'h5A;
        run({5'b01110, 1'b1, 2'b00}, 2, 0, 1'b0);
        chk(mon_n == 1, "R1 id match with id_sel=1", mon_n, 1);
        run({5'b01110, 1'b0, 2'b00}, 2, 0, 1'b0);
        chk(mon_n == 0, "R1 id mismatch with id_sel=1", mon_n, 0);
        id_sel = 1'b0;
        // R2: wrong prefix, read attempt ignored.
        run({5'b01100, 1'b0, 2'b11}, 8, 0, 1'b0);
        // R7: odd byte count plus partial bits discarded.
        txb[0] = 8'hC3; txb[1] = 8'h3C; txb[2] = 8'h99;
        run({5'b01110, 1'b0, 2'b00}, 3, 5, 1'b0);
        chk(mon_n == 1, "R7 lone byte discarded", mon_n, 1);
        txb[0] = 8'h0F; txb[1] = 8'hF0;
        run({5'b01110, 1'b0, 2'b00}, 2, 0, 1'b0);
        chk(mon_n == 1 && mon_word[0] == 16'h0FF0, "R7 fresh header", mon_word[0], 16'h0FF0);
        // R9 R10: status read and data read.
        for (int i = 0; i < 12; i++) txb[i] = 8'($urandom);
        run({5'b01110, 1'b0, 2'b01}, 8, 0, 1'b0);
        run({5'b01110, 1'b0, 2'b11}, 10, 3, 1'b0);

        // Random mix.
        for (int t = 0; t < 30; t++) begin
            logic [7:0] sb;
            int nb;
            if (($urandom % 4) == 0) id_sel = 1'($urandom);
            sb = {5'b01110, id_sel, 2'($urandom)};
            if (($urandom % 7) == 0) sb[2] = !sb[2];
            if (($urandom % 9) == 0) sb[7:3] = 5'($urandom);
            nb = int'($urandom % 11);
            for (int i = 0; i < 12; i++) txb[i] = 8'($urandom);
            run(sb, nb, int'($urandom % 8), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule